// File: doc/BRIEF.md
# Operand-Snooping Reservation Station

This block buffers decoded instructions in front of one functional unit of an out-of-order core. Each instruction arrives with a result tag, a field of control bits and two source operands. A source is either a value or the tag of the instruction that will produce it. The block holds up to four waiting instructions. It watches the result broadcast bus and fills in any missing source whose producer tag appears there. As soon as the unit can take new work, the block hands an instruction with both operands complete to the unit's input registers.

Slots that are ready are chosen in rotating order, starting after the slot that was sent last. A freshly issued instruction that is already complete goes straight to the unit, without being stored, when no stored slot is ready. The block also tells the issue stage when it cannot accept an instruction, and tells the bus arbiter when the unit is holding a result. Tag value zero means "no instruction" everywhere. A flush drops every buffered instruction.

Top module: `resv_station`

## Requirements
- R1: After reset, `disp_valid_o` and `full_o` are 0 and `disp_tag_o` is 0. All slots are empty, and the first rotating search starts at slot 0.
- R2: A slot whose stored tag is 0 is empty. When nothing is dispatched, `disp_valid_o` is 0 and `disp_tag_o`, `disp_ctrl_o`, `disp_src1_o` and `disp_src2_o` are 0. A tag of 0 on the broadcast bus matches no source.
- R3: The unit can accept work when `fu_tag_i` is 0 or `fu_ack_i` is 1. A stored slot is dispatched only then, and only when both of its sources are available.
- R4: After slot k has been dispatched, slots are searched in the order k+1, k+2, k+3, k (modulo 4), and the first ready slot is sent.
- R5: An issued instruction is dispatched in the same cycle and is not stored when three things hold: the unit can accept work, both of its sources are available, and no stored slot is ready.
- R6: A stored source with its valid bit clear captures `bus_data_i` and sets its valid bit when the low TAG_W bits of the source equal a nonzero `bus_tag_i`. Any other stored field keeps its value.
- R7: A slot whose missing source matches the broadcast tag in the current cycle counts as ready. It is dispatched with `bus_data_i` in place of that source.
- R8: On insertion or bypass, an incoming source with its valid bit clear whose low TAG_W bits equal a nonzero `bus_tag_i` is replaced by `bus_data_i`.
- R9: An issued instruction is rejected, with no insertion, no bypass and no full, in two cases: its tag equals the tag of an occupied slot, or its tag equals a nonzero `fu_tag_i`. An issued tag of 0 is also ignored.
- R10: `full_o` is 1 exactly when an acceptable instruction is issued, nothing is dispatched this cycle and no slot is empty. That instruction is then dropped.
- R11: An accepted instruction that is not bypassed goes into the lowest-numbered free slot. A slot dispatched in the same cycle counts as free.
- R12: `done_o` is 1 exactly when `fu_tag_i` is nonzero.
- R13: While `flush_i` is 1, nothing is dispatched or inserted and `full_o` is 0. Afterwards all slots are empty and the rotating search restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop all buffered instructions |
| issue_valid_i | input | 1 | An instruction is issued to this station |
| issue_tag_i | input | TAG_W | Result tag of the issued instruction |
| issue_ctrl_i | input | CTRL_W | Control bits of the issued instruction |
| issue_src1_i | input | DATA_W | First source: value, or producer tag in the low bits |
| issue_src1_vld_i | input | 1 | 1: first source holds a value |
| issue_src2_i | input | DATA_W | Second source: value, or producer tag in the low bits |
| issue_src2_vld_i | input | 1 | 1: second source holds a value |
| bus_tag_i | input | TAG_W | Tag on the result broadcast bus, 0 when idle |
| bus_data_i | input | DATA_W | Value on the result broadcast bus |
| fu_tag_i | input | TAG_W | Content of the unit's tag register |
| fu_ack_i | input | 1 | Arbiter accepted the unit's result this cycle |
| disp_valid_o | output | 1 | An instruction is sent to the unit this cycle |
| disp_tag_o | output | TAG_W | Tag for the unit's tag register |
| disp_ctrl_o | output | CTRL_W | Control bits for the unit |
| disp_src1_o | output | DATA_W | First operand for the unit |
| disp_src2_o | output | DATA_W | Second operand for the unit |
| full_o | output | 1 | Issued instruction cannot be accepted; issue stalls |
| done_o | output | 1 | Unit holds a result for the arbiter |

## Verification
The properties assume four things about the surroundings. `fu_tag_i` is the tag register that is loaded from the dispatch outputs. The arbiter raises `fu_ack_i` only while that register is nonzero. No tag is issued twice while still in flight, except where the rejection rule is being exercised on purpose. The bench drives `fu_tag_i` with the tag it last saw dispatched, and asserts the acknowledge only in cycles where that tag is nonzero. Issued and broadcast tags are chosen so that each producer tag appears on the bus at most once while its consumers wait.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_SLOT  = 2'd1,
    SEL_ISSUE = 2'd2
  } sel_src_e;
endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic              vld_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              avail_o,
  output logic [DATA_W-1:0] val_o
);
  logic hit;

  assign hit     = !vld_i && (bus_tag_i != '0) && (src_i[TAG_W-1:0] == bus_tag_i);
  assign avail_o = vld_i | hit;
  assign val_o   = hit ? bus_data_i : src_i;
endmodule

// File: rtl/rs_slot.sv
module rs_slot #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [CTRL_W-1:0] in_ctrl_i,
  input  logic [DATA_W-1:0] in_src1_i,
  input  logic              in_vld1_i,
  input  logic [DATA_W-1:0] in_src2_i,
  input  logic              in_vld2_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              busy_o,
  output logic              avail_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] op1_o,
  output logic [DATA_W-1:0] op2_o
);
  logic [TAG_W-1:0]  tag_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] src1_q, src2_q;
  logic              vld1_q, vld2_q;
  logic              av1, av2;

  rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_op1 (
    .src_i(src1_q), .vld_i(vld1_q), .bus_tag_i(bus_tag_i), .bus_data_i(bus_data_i),
    .avail_o(av1), .val_o(op1_o)
  );
  rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_op2 (
    .src_i(src2_q), .vld_i(vld2_q), .bus_tag_i(bus_tag_i), .bus_data_i(bus_data_i),
    .avail_o(av2), .val_o(op2_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      ctrl_q <= '0;
      src1_q <= '0;
      src2_q <= '0;
      vld1_q <= 1'b0;
      vld2_q <= 1'b0;
    end else if (flush_i) begin
      tag_q  <= '0;
      vld1_q <= 1'b0;
      vld2_q <= 1'b0;
    end else if (load_i) begin
      // incoming operands arrive already bus-forwarded
      tag_q  <= in_tag_i;
      ctrl_q <= in_ctrl_i;
      src1_q <= in_src1_i;
      vld1_q <= in_vld1_i;
      src2_q <= in_src2_i;
      vld2_q <= in_vld2_i;
    end else if (clear_i) begin
      tag_q  <= '0;
    end else if (tag_q != '0) begin
      src1_q <= op1_o;
      vld1_q <= av1;
      src2_q <= op2_o;
      vld2_q <= av2;
    end
  end

  assign busy_o  = (tag_q != '0);
  assign avail_o = busy_o & av1 & av2;
  assign tag_o   = tag_q;
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/rs_picker.sv
module rs_picker
  import rs_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [N-1:0]     slot_rdy_i,
  input  logic             issue_rdy_i,
  output sel_src_e         src_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] last_q;

  function automatic logic [IDX_W-1:0] wrap_idx(input logic [IDX_W-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= N) s = s - N;
    return IDX_W'(s);
  endfunction

  always_comb begin
    src_o = SEL_NONE;
    idx_o = '0;
    for (int off = 1; off <= N; off++) begin
      if (src_o == SEL_NONE && slot_rdy_i[wrap_idx(last_q, off)]) begin
        src_o = SEL_SLOT;
        idx_o = wrap_idx(last_q, off);
      end
    end
    if (src_o == SEL_NONE && issue_rdy_i) src_o = SEL_ISSUE;
  end

  // last slot sent; reset value makes slot 0 first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                last_q <= IDX_W'(N-1);
    else if (flush_i)           last_q <= IDX_W'(N-1);
    else if (src_o == SEL_SLOT) last_q <= idx_o;
  end
endmodule

// File: rtl/resv_station.sv
module resv_station
  import rs_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              issue_valid_i,
  input  logic [TAG_W-1:0]  issue_tag_i,
  input  logic [CTRL_W-1:0] issue_ctrl_i,
  input  logic [DATA_W-1:0] issue_src1_i,
  input  logic              issue_src1_vld_i,
  input  logic [DATA_W-1:0] issue_src2_i,
  input  logic              issue_src2_vld_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [TAG_W-1:0]  fu_tag_i,
  input  logic              fu_ack_i,
  output logic              disp_valid_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  output logic [CTRL_W-1:0] disp_ctrl_o,
  output logic [DATA_W-1:0] disp_src1_o,
  output logic [DATA_W-1:0] disp_src2_o,
  output logic              full_o,
  output logic              done_o
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0]  s_busy, s_avail, s_rdy, s_free, s_load, s_clear;
  logic [TAG_W-1:0]  s_tag  [SLOTS];
  logic [CTRL_W-1:0] s_ctrl [SLOTS];
  logic [DATA_W-1:0] s_op1  [SLOTS];
  logic [DATA_W-1:0] s_op2  [SLOTS];

  logic              fu_ready;
  logic              in_av1, in_av2;
  logic [DATA_W-1:0] in_val1, in_val2;
  logic              redundant, issue_ok, issue_rdy;
  logic              any_free, any_empty, insert;
  logic [IDX_W-1:0]  ins_idx;
  sel_src_e          sel_src;
  logic [IDX_W-1:0]  sel_idx;

  assign fu_ready = (fu_tag_i == '0) | fu_ack_i;
  assign done_o   = (fu_tag_i != '0);

  rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_in1 (
    .src_i(issue_src1_i), .vld_i(issue_src1_vld_i), .bus_tag_i(bus_tag_i),
    .bus_data_i(bus_data_i), .avail_o(in_av1), .val_o(in_val1)
  );
  rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_in2 (
    .src_i(issue_src2_i), .vld_i(issue_src2_vld_i), .bus_tag_i(bus_tag_i),
    .bus_data_i(bus_data_i), .avail_o(in_av2), .val_o(in_val2)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rs_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .load_i    (s_load[g]),
      .clear_i   (s_clear[g]),
      .in_tag_i  (issue_tag_i),
      .in_ctrl_i (issue_ctrl_i),
      .in_src1_i (in_val1),
      .in_vld1_i (in_av1),
      .in_src2_i (in_val2),
      .in_vld2_i (in_av2),
      .bus_tag_i (bus_tag_i),
      .bus_data_i(bus_data_i),
      .busy_o    (s_busy[g]),
      .avail_o   (s_avail[g]),
      .tag_o     (s_tag[g]),
      .ctrl_o    (s_ctrl[g]),
      .op1_o     (s_op1[g]),
      .op2_o     (s_op2[g])
    );
    assign s_rdy[g]   = s_avail[g] & fu_ready & !flush_i;
    assign s_clear[g] = (sel_src == SEL_SLOT) && (sel_idx == IDX_W'(g));
    assign s_free[g]  = !s_busy[g] | s_clear[g];
    assign s_load[g]  = insert && (ins_idx == IDX_W'(g));
  end

  always_comb begin
    redundant = (fu_tag_i != '0) && (fu_tag_i == issue_tag_i);
    for (int i = 0; i < SLOTS; i++)
      if (s_busy[i] && s_tag[i] == issue_tag_i) redundant = 1'b1;
  end

  assign issue_ok  = issue_valid_i && (issue_tag_i != '0) && !redundant && !flush_i;
  assign issue_rdy = issue_ok & fu_ready & in_av1 & in_av2;

  rs_picker #(.N(SLOTS), .IDX_W(IDX_W)) u_pick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .slot_rdy_i (s_rdy),
    .issue_rdy_i(issue_rdy),
    .src_o      (sel_src),
    .idx_o      (sel_idx)
  );

  // lowest free slot
  always_comb begin
    ins_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (s_free[i]) ins_idx = IDX_W'(i);
  end

  assign any_free  = |s_free;
  assign any_empty = ~&s_busy;
  assign insert    = issue_ok && (sel_src != SEL_ISSUE) && any_free;
  assign full_o    = issue_ok && (sel_src == SEL_NONE) && !any_empty;

  always_comb begin
    disp_valid_o = 1'b0;
    disp_tag_o   = '0;
    disp_ctrl_o  = '0;
    disp_src1_o  = '0;
    disp_src2_o  = '0;
    unique case (sel_src)
      SEL_SLOT: begin
        disp_valid_o = 1'b1;
        disp_tag_o   = s_tag[sel_idx];
        disp_ctrl_o  = s_ctrl[sel_idx];
        disp_src1_o  = s_op1[sel_idx];
        disp_src2_o  = s_op2[sel_idx];
      end
      SEL_ISSUE: begin
        disp_valid_o = 1'b1;
        disp_tag_o   = issue_tag_i;
        disp_ctrl_o  = issue_ctrl_i;
        disp_src1_o  = in_val1;
        disp_src2_o  = in_val2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int TAG_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             issue_valid_i,
  input logic [TAG_W-1:0] fu_tag_i,
  input logic             fu_ack_i,
  input logic             disp_valid_o,
  input logic [TAG_W-1:0] disp_tag_o,
  input logic             full_o
);
  logic flush_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_d <= 1'b0;
    else         flush_d <= flush_i;
  end

  // R3
  disp_needs_fu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (fu_tag_i == '0 || fu_ack_i));

  // R2
  disp_tag_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> disp_tag_o != '0);

  // R2
  idle_tag_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_valid_o |-> disp_tag_o == '0);

  // R10
  full_no_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (!disp_valid_o && issue_valid_i));

  // R13
  flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!disp_valid_o && !full_o));

  // R13
  post_flush_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_d && !flush_i && !issue_valid_i) |-> !disp_valid_o);

  // R9
  no_dup_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && fu_tag_i != '0) |-> disp_tag_o != fu_tag_i);
endmodule

bind resv_station rs_checker #(.TAG_W(TAG_W)) i_rs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .issue_valid_i(issue_valid_i),
  .fu_tag_i     (fu_tag_i),
  .fu_ack_i     (fu_ack_i),
  .disp_valid_o (disp_valid_o),
  .disp_tag_o   (disp_tag_o),
  .full_o       (full_o)
);

// File: tb/test_resv_station.sv
module test_resv_station;
  localparam int TAG_W  = 3;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 4;

  typedef struct packed {
    logic [3:0]        req;
    logic              iv;
    logic [TAG_W-1:0]  itag;
    logic [DATA_W-1:0] s1;
    logic              v1;
    logic [DATA_W-1:0] s2;
    logic              v2;
    logic [TAG_W-1:0]  btag;
    logic [DATA_W-1:0] bdata;
    logic [TAG_W-1:0]  futag;
    logic              ack;
    logic              edv;
    logic [TAG_W-1:0]  etag;
    logic [DATA_W-1:0] es1;
    logic [DATA_W-1:0] es2;
    logic              efull;
    logic              edone;
  } vec_t;

  // fields: req, iv,itag,s1,v1,s2,v2, btag,bdata, futag,ack | dv,tag,s1,s2,full,done
  localparam vec_t VEC [16] = '{
    '{4'd3,  1,1,32'h5,0,32'h10,1,   0,32'h0,  7,0,  0,0,32'h0,32'h0,0,1},   // R3 unit busy, stored
    '{4'd3,  1,2,32'h20,1,32'h21,1,  0,32'h0,  7,0,  0,0,32'h0,32'h0,0,1},   // R3
    '{4'd3,  1,3,32'h6,0,32'h30,1,   0,32'h0,  7,0,  0,0,32'h0,32'h0,0,1},   // R3
    '{4'd8,  1,4,32'h40,1,32'h6,0,   6,32'h66, 7,0,  0,0,32'h0,32'h0,0,1},   // R8 insert capture, R6 snoop slot2
    '{4'd10, 1,5,32'h50,1,32'h51,1,  0,32'h0,  7,0,  0,0,32'h0,32'h0,1,1},   // R10 full
    '{4'd9,  1,2,32'h52,1,32'h53,1,  0,32'h0,  7,0,  0,0,32'h0,32'h0,0,1},   // R9 redundant, no full
    '{4'd4,  0,0,32'h0,0,32'h0,0,    0,32'h0,  0,0,  1,2,32'h20,32'h21,0,0}, // R4 slot1 first ready
    '{4'd6,  0,0,32'h0,0,32'h0,0,    0,32'h0,  2,1,  1,3,32'h66,32'h30,0,1}, // R6 snooped value
    '{4'd4,  0,0,32'h0,0,32'h0,0,    5,32'h55, 3,1,  1,4,32'h40,32'h66,0,1}, // R4 slot3 ahead of slot0
    '{4'd6,  0,0,32'h0,0,32'h0,0,    0,32'h0,  4,1,  1,1,32'h55,32'h10,0,1}, // R6
    '{4'd2,  0,0,32'h0,0,32'h0,0,    0,32'h0,  1,1,  0,0,32'h0,32'h0,0,1},   // R2 empty
    '{4'd5,  1,6,32'h3,0,32'h61,1,   3,32'h77, 0,0,  1,6,32'h77,32'h61,0,0}, // R5 bypass, R8
    '{4'd5,  0,0,32'h0,0,32'h0,0,    0,32'h0,  6,1,  0,0,32'h0,32'h0,0,1},   // R5 not stored
    '{4'd12, 1,1,32'h4,0,32'h11,1,   0,32'h0,  7,0,  0,0,32'h0,32'h0,0,1},   // R12 done high
    '{4'd7,  0,0,32'h0,0,32'h0,0,    4,32'h44, 0,0,  1,1,32'h44,32'h11,0,0}, // R7 same-cycle bus
    '{4'd2,  0,0,32'h0,0,32'h0,0,    0,32'h0,  1,1,  0,0,32'h0,32'h0,0,1}    // R2
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              flush_i = 1'b0;
  logic              issue_valid_i = 1'b0;
  logic [TAG_W-1:0]  issue_tag_i = '0;
  logic [CTRL_W-1:0] issue_ctrl_i = '0;
  logic [DATA_W-1:0] issue_src1_i = '0;
  logic              issue_src1_vld_i = 1'b0;
  logic [DATA_W-1:0] issue_src2_i = '0;
  logic              issue_src2_vld_i = 1'b0;
  logic [TAG_W-1:0]  bus_tag_i = '0;
  logic [DATA_W-1:0] bus_data_i = '0;
  logic [TAG_W-1:0]  fu_tag_i = '0;
  logic              fu_ack_i = 1'b0;
  logic              disp_valid_o;
  logic [TAG_W-1:0]  disp_tag_o;
  logic [CTRL_W-1:0] disp_ctrl_o;
  logic [DATA_W-1:0] disp_src1_o;
  logic [DATA_W-1:0] disp_src2_o;
  logic              full_o;
  logic              done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  resv_station #(.TAG_W(TAG_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_resv_station (
    .clk_i, .rst_ni, .flush_i, .issue_valid_i, .issue_tag_i, .issue_ctrl_i,
    .issue_src1_i, .issue_src1_vld_i, .issue_src2_i, .issue_src2_vld_i,
    .bus_tag_i, .bus_data_i, .fu_tag_i, .fu_ack_i, .disp_valid_o, .disp_tag_o,
    .disp_ctrl_o, .disp_src1_o, .disp_src2_o, .full_o, .done_o
  );

  task automatic run(input vec_t v, input logic fl);
    logic [69:0] act, exp;
    @(negedge clk_i);
    flush_i          = fl;
    issue_valid_i    = v.iv;
    issue_tag_i      = v.itag;
    issue_ctrl_i     = {1'b0, v.itag};
    issue_src1_i     = v.s1;
    issue_src1_vld_i = v.v1;
    issue_src2_i     = v.s2;
    issue_src2_vld_i = v.v2;
    bus_tag_i        = v.btag;
    bus_data_i       = v.bdata;
    fu_tag_i         = v.futag;
    fu_ack_i         = v.ack;
    #1;
    act = {disp_valid_o, disp_tag_o, disp_src1_o, disp_src2_o, full_o, done_o};
    exp = {v.edv, v.etag, v.es1, v.es2, v.efull, v.edone};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d act=%h exp=%h", v.req, act, exp);
    end
  endtask

  // build a directed step: issue fields, unit state, expected dispatch
  function automatic vec_t st(input logic [3:0] r, input logic iv, input logic [2:0] it,
                              input logic [31:0] a, input logic [31:0] b,
                              input logic [2:0] ft, input logic ak,
                              input logic dv, input logic [2:0] dt,
                              input logic [31:0] da, input logic [31:0] db,
                              input logic fu);
    vec_t v;
    v = '0;
    v.req = r; v.iv = iv; v.itag = it; v.s1 = a; v.v1 = 1'b1; v.s2 = b; v.v2 = 1'b1;
    v.futag = ft; v.ack = ak; v.edv = dv; v.etag = dt; v.es1 = da; v.es2 = db;
    v.efull = fu; v.edone = (ft != 0);
    return v;
  endfunction

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    run(st(4'd1, 0,0,0,0, 0,0, 0,0,0,0, 0), 1'b0);

    foreach (VEC[i]) run(VEC[i], 1'b0);

    // R13 flush drops a ready stored entry
    run(st(4'd13, 1,1,32'hA1,32'hA2, 7,0, 0,0,0,0, 0), 1'b0);
    run(st(4'd13, 1,2,32'hB1,32'hB2, 0,0, 0,0,0,0, 0), 1'b1);
    run(st(4'd13, 0,0,0,0, 0,0, 0,0,0,0, 0), 1'b0);

    // R11 fill in order, refill dispatched slot; R4 rotation wraps
    for (int t = 1; t <= 4; t++)
      run(st(4'd11, 1,3'(t),32'(t*16+1),32'(t*16+2), 7,0, 0,0,0,0, 0), 1'b0);
    run(st(4'd11, 1,5,32'h51,32'h52, 0,0, 1,1,32'h11,32'h12, 0), 1'b0);
    for (int t = 2; t <= 4; t++)
      run(st(4'd4, 0,0,0,0, 3'(t-1),1, 1,3'(t),32'(t*16+1),32'(t*16+2), 0), 1'b0);
    run(st(4'd11, 0,0,0,0, 4,1, 1,5,32'h51,32'h52, 0), 1'b0);
    run(st(4'd4, 0,0,0,0, 5,1, 0,0,0,0, 0), 1'b0);

    // R9 duplicate of stored tag and of unit tag are dropped
    run(st(4'd9, 1,2,32'hA,32'hB, 7,0, 0,0,0,0, 0), 1'b0);
    run(st(4'd9, 1,2,32'hC,32'hD, 7,0, 0,0,0,0, 0), 1'b0);
    run(st(4'd9, 1,7,32'hE,32'hF, 7,0, 0,0,0,0, 0), 1'b0);
    run(st(4'd9, 0,0,0,0, 0,0, 1,2,32'hA,32'hB, 0), 1'b0);
    run(st(4'd9, 0,0,0,0, 2,1, 0,0,0,0, 0), 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule